// File: doc/BRIEF.md
# Hierarchical Interrupt Status Encoder

This block gathers interrupt requests from three source groups and presents the winner of each group in one read-only status word. The three groups are a critical group of 4 sources, a main group of 17 sources and a peripheral group of 32 sources. Each group has its own mask, where a 1 disables a source. Inside a group the lowest-numbered enabled pending source wins. The processor reads the word and looks at the critical field first, then the main field, then the peripheral field.

The groups are linked by fixed source numbers. Peripheral source 0 is not a pin. It is the combined request of a DMA event block, which has 32 sticky pending bits, its own mask, and write-one-to-clear acknowledge. Critical source 2 is driven by the peripheral group's high-priority class, which is peripheral indices 0 to 3. Main source 4 is driven by the peripheral group's low-priority class, which is indices 4 and up. When software sees either of these codes, it reads the peripheral field.

Request lines are sampled into registers on every clock. The status word is combinational logic over the registered request and mask state.

Top module: `irq_status_encoder`

## Requirements
- R1: During reset and afterwards, until masks are written, all masks are all ones, DMA pending bits are clear, and status reads 0 whatever the request lines do.
- R2: Status layout:
  - Critical group: flag at bit 10, number at bits 9:8.
  - Main group: flag at bit 21, number at bits 20:16.
  - Peripheral group: flag at bit 29, number at bits 28:24.
  - All other bits are 0.
  - A group with no enabled pending source has flag 0 and number 0.
- R3: Request lines are captured at each rising clock edge. Status shows the levels captured at the latest edge, so it lags the pins by one cycle. A configuration write affects status from the cycle after its edge.
- R4: Within each group, the lowest-numbered source that is pending and enabled is reported.
- R5: Mask mapping, where a 1 disables the source:
  - Critical source n uses critical-mask bit n.
  - Main source n (n<16) uses main-mask bit 15-n, and main source 16 uses bit 16.
  - Peripheral source n uses peripheral-mask bit 31-n.
- R6: Peripheral source 0 is active while any DMA pending bit is set whose DMA-mask bit (bit n for event n) is 0. The pin periph_req[0] has no effect.
- R7: Critical source 2 is active while any enabled pending peripheral source with index 0 to 3 exists. The pin crit_req[2] has no effect.
- R8: Main source 4 is active while any enabled pending peripheral source with index 4 or higher exists. The pin main_req[4] has no effect.
- R9: DMA event handling:
  - A DMA pending bit is set by a 1 on dma_evt and holds until a write with cfg_sel=4 carries a 1 in that bit.
  - A set and a clear in the same cycle leave the bit set.
  - Masking a DMA bit hides it without clearing it.
- R10: After writing 0x00010FFF to the main mask and 0x7FFFFC00 to the peripheral mask, only these sources remain enabled: main 0 to 3, and peripheral 0 and 22 to 31.
- R11: Configuration writes select their target with cfg_sel: 0 critical mask, 1 main mask, 2 peripheral mask, 3 DMA mask, 4 DMA pending clear. Writes with cfg_sel 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| crit_req | input | 4 | Critical group request levels (bit 2 unused) |
| main_req | input | 17 | Main group request levels (bit 4 unused) |
| periph_req | input | 32 | Peripheral group request levels (bit 0 unused) |
| dma_evt | input | 32 | DMA event pulses, each sets a sticky pending bit |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration target select |
| cfg_wdata | input | 32 | Configuration write data |
| status | output | 32 | Encoded status word |

## Verification
The hardest situation to reach is a critical or main code that exists only because of a peripheral request two levels away. One example is a DMA event that must be pending, then unmasked in the DMA block, then enabled in the peripheral mask before critical code 2 appears. Directed sequences build this chain one step at a time, then take it apart with a masked DMA bit, a write-one-to-clear acknowledge, and a set and clear landing on the same edge. A long run with random request levels, random writes to every select value and sparse DMA events then compares the whole status word against a behavioural model on every cycle. That run reaches mixes of the two peripheral classes that the directed cases do not cover.

// File: rtl/irq_enc_pkg.sv
package irq_enc_pkg;

    // Status word field positions (the processor decodes these)
    localparam int CRIT_FLAG_BIT = 10;
    localparam int CRIT_NUM_LSB  = 8;
    localparam int CRIT_NUM_W    = 2;
    localparam int MAIN_FLAG_BIT = 21;
    localparam int MAIN_NUM_LSB  = 16;
    localparam int PER_FLAG_BIT  = 29;
    localparam int PER_NUM_LSB   = 24;
    localparam int GRP_NUM_W     = 5;
    localparam int STATUS_W      = 32;

    typedef enum logic [2:0] {
        SEL_CRIT_MASK = 3'd0,
        SEL_MAIN_MASK = 3'd1,
        SEL_PER_MASK  = 3'd2,
        SEL_DMA_MASK  = 3'd3,
        SEL_DMA_CLR   = 3'd4
    } cfg_sel_e;

endpackage

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          valid,
    output logic [IW-1:0] idx
);

    always_comb begin
        valid = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end

    // Reported index must be pending, and nothing below it may be pending
    always_comb begin
        if (valid) begin
            assert_pick_hit_R4: assert (req[idx])
                else $error("picked index is not pending");
            assert_pick_lowest_R4: assert ((req & ((N'(1) << idx) - N'(1))) == '0)
                else $error("a lower index was pending");
        end
    end

endmodule

// File: rtl/irq_dma_agg.sv
module irq_dma_agg #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic         mask_we,
    input  logic         clr_we,
    input  logic [N-1:0] wdata,
    output logic         any_active
);

    typedef struct packed {
        logic [N-1:0] pend;
        logic [N-1:0] mask;
    } dma_state_t;

    dma_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mask_we) st_d.mask = wdata;
        if (clr_we)  st_d.pend = st_d.pend & ~wdata;
        st_d.pend = st_d.pend | evt;   // a new event wins over an acknowledge
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pend <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign any_active = |(st_q.pend & ~st_q.mask);

    // Acknowledged bits without a coincident event end up clear
    assert_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((st_q.pend & $past(wdata & ~evt)) == '0))
        else $error("acknowledged pending bit still set");

    // Pending bits never drop without an acknowledge
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> ((st_q.pend & $past(st_q.pend)) == $past(st_q.pend)))
        else $error("pending bit lost without acknowledge");

endmodule

// File: rtl/irq_status_encoder.sv
module irq_status_encoder
    import irq_enc_pkg::*;
#(
    parameter int N_CRIT    = 4,
    parameter int N_MAIN    = 17,
    parameter int N_PER     = 32,
    parameter int N_DMA     = 32,
    parameter int HI_PER    = 4,
    parameter int CRIT_LINK = 2,
    parameter int MAIN_LINK = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_CRIT-1:0]   crit_req,
    input  logic [N_MAIN-1:0]   main_req,
    input  logic [N_PER-1:0]    periph_req,
    input  logic [N_DMA-1:0]    dma_evt,
    input  logic                cfg_we,
    input  logic [2:0]          cfg_sel,
    input  logic [31:0]         cfg_wdata,
    output logic [STATUS_W-1:0] status
);

    localparam logic [N_CRIT-1:0] CRIT_LINK_BIT = N_CRIT'(1) << CRIT_LINK;
    localparam logic [N_MAIN-1:0] MAIN_LINK_BIT = N_MAIN'(1) << MAIN_LINK;
    localparam logic [N_PER-1:0]  PER_DMA_BIT   = N_PER'(1);

    typedef struct packed {
        logic [N_CRIT-1:0] crit_p;
        logic [N_MAIN-1:0] main_p;
        logic [N_PER-1:0]  per_p;
        logic [N_CRIT-1:0] crit_mask;
        logic [N_MAIN-1:0] main_mask;
        logic [N_PER-1:0]  per_mask;
    } enc_state_t;

    enc_state_t st_d, st_q;

    // ---------------- state update ----------------
    always_comb begin
        st_d        = st_q;
        // linked slots are fed internally, so their pins are stripped here
        st_d.crit_p = crit_req   & ~CRIT_LINK_BIT;
        st_d.main_p = main_req   & ~MAIN_LINK_BIT;
        st_d.per_p  = periph_req & ~PER_DMA_BIT;
        if (cfg_we) begin
            case (cfg_sel_e'(cfg_sel))
                SEL_CRIT_MASK: st_d.crit_mask = cfg_wdata[N_CRIT-1:0];
                SEL_MAIN_MASK: st_d.main_mask = cfg_wdata[N_MAIN-1:0];
                SEL_PER_MASK:  st_d.per_mask  = cfg_wdata[N_PER-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.crit_p    <= '0;
            st_q.main_p    <= '0;
            st_q.per_p     <= '0;
            st_q.crit_mask <= '1;
            st_q.main_mask <= '1;
            st_q.per_mask  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    // ---------------- DMA aggregate ----------------
    logic dma_any;

    irq_dma_agg #(.N(N_DMA)) u_dma (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (dma_evt),
        .mask_we    (cfg_we && (cfg_sel == SEL_DMA_MASK)),
        .clr_we     (cfg_we && (cfg_sel == SEL_DMA_CLR)),
        .wdata      (cfg_wdata[N_DMA-1:0]),
        .any_active (dma_any)
    );

    // ---------------- enables from masks ----------------
    logic [N_MAIN-1:0] main_en;
    logic [N_PER-1:0]  per_en;

    for (genvar n = 0; n < N_MAIN; n++) begin : g_main_en
        assign main_en[n] = ~st_q.main_mask[(n < 16) ? (15 - n) : n];
    end

    for (genvar n = 0; n < N_PER; n++) begin : g_per_en
        assign per_en[n] = ~st_q.per_mask[N_PER - 1 - n];
    end

    // ---------------- group inputs with cross-links ----------------
    logic [N_PER-1:0]  per_live;
    logic [N_CRIT-1:0] crit_live;
    logic [N_MAIN-1:0] main_live;
    logic              hi_link, lo_link;

    assign per_live  = (st_q.per_p | (dma_any ? PER_DMA_BIT : '0)) & per_en;
    assign hi_link   = |per_live[HI_PER-1:0];
    assign lo_link   = |per_live[N_PER-1:HI_PER];
    assign crit_live = (st_q.crit_p | (hi_link ? CRIT_LINK_BIT : '0)) & ~st_q.crit_mask;
    assign main_live = (st_q.main_p | (lo_link ? MAIN_LINK_BIT : '0)) & main_en;

    // ---------------- per-group winners ----------------
    logic                  crit_v, main_v, per_v;
    logic [CRIT_NUM_W-1:0] crit_idx;
    logic [GRP_NUM_W-1:0]  main_idx, per_idx;

    irq_lowest_pick #(.N(N_CRIT), .IW(CRIT_NUM_W)) u_pick_crit (
        .req (crit_live), .valid (crit_v), .idx (crit_idx));

    irq_lowest_pick #(.N(N_MAIN), .IW(GRP_NUM_W)) u_pick_main (
        .req (main_live), .valid (main_v), .idx (main_idx));

    irq_lowest_pick #(.N(N_PER), .IW(GRP_NUM_W)) u_pick_per (
        .req (per_live), .valid (per_v), .idx (per_idx));

    // ---------------- status assembly ----------------
    always_comb begin
        status = '0;
        status[CRIT_FLAG_BIT]                      = crit_v;
        status[CRIT_NUM_LSB +: CRIT_NUM_W]         = crit_v ? crit_idx : '0;
        status[MAIN_FLAG_BIT]                      = main_v;
        status[MAIN_NUM_LSB +: GRP_NUM_W]          = main_v ? main_idx : '0;
        status[PER_FLAG_BIT]                       = per_v;
        status[PER_NUM_LSB +: GRP_NUM_W]           = per_v ? per_idx : '0;
    end

    // ---------------- assertions ----------------
    assert_crit_link_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (status[CRIT_FLAG_BIT] &&
         status[CRIT_NUM_LSB +: CRIT_NUM_W] == CRIT_NUM_W'(CRIT_LINK))
        |-> status[PER_FLAG_BIT])
        else $error("critical link code without a peripheral winner");

    assert_main_link_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (status[MAIN_FLAG_BIT] &&
         status[MAIN_NUM_LSB +: GRP_NUM_W] == GRP_NUM_W'(MAIN_LINK))
        |-> status[PER_FLAG_BIT])
        else $error("main link code without a peripheral winner");

    assert_dma_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (status[PER_FLAG_BIT] && status[PER_NUM_LSB +: GRP_NUM_W] == '0)
        |-> dma_any)
        else $error("peripheral code 0 without an active DMA request");

    assert_main_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == SEL_MAIN_MASK && (&cfg_wdata[N_MAIN-1:0]))
        |=> !status[MAIN_FLAG_BIT])
        else $error("main group reported with every source masked");

endmodule

// File: tb/irq_status_encoder_test.sv
module irq_status_encoder_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  crit_req;
    logic [16:0] main_req;
    logic [31:0] periph_req;
    logic [31:0] dma_evt;
    logic        cfg_we;
    logic [2:0]  cfg_sel;
    logic [31:0] cfg_wdata;
    logic [31:0] status;

    always #4 clk = ~clk;   // 125 MHz

    irq_status_encoder uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .crit_req   (crit_req),
        .main_req   (main_req),
        .periph_req (periph_req),
        .dma_evt    (dma_evt),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .status     (status)
    );

    int    checks = 0;
    int    errors = 0;
    string phase  = "R1";
    bit    finished = 1'b0;

    // ---------------- behavioural reference model ----------------
    bit [3:0]  m_crit, m_cmask;
    bit [16:0] m_main, m_mmask;
    bit [31:0] m_per, m_pmask, m_dpend, m_dmask;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_crit = '0; m_main = '0; m_per = '0; m_dpend = '0;
            m_cmask = '1; m_mmask = '1; m_pmask = '1; m_dmask = '1;
        end else begin
            if (cfg_we && cfg_sel == 3'd4) m_dpend = m_dpend & ~cfg_wdata;
            m_dpend = m_dpend | dma_evt;
            if (cfg_we) begin
                case (cfg_sel)
                    3'd0: m_cmask = cfg_wdata[3:0];
                    3'd1: m_mmask = cfg_wdata[16:0];
                    3'd2: m_pmask = cfg_wdata;
                    3'd3: m_dmask = cfg_wdata;
                    default: ;
                endcase
            end
            m_crit = crit_req;
            m_main = main_req;
            m_per  = periph_req;
        end
    end

    function automatic bit [31:0] model_status();
        int pw = -1, cw = -1, mw = -1;
        bit hi = 1'b0, lo = 1'b0, on;
        bit [31:0] r = '0;
        for (int n = 0; n < 32; n++) begin
            on = (n == 0) ? ((m_dpend & ~m_dmask) != 0) : m_per[n];
            if (on && !m_pmask[31 - n]) begin
                if (pw < 0) pw = n;
                if (n < 4) hi = 1'b1; else lo = 1'b1;
            end
        end
        for (int n = 0; n < 4; n++) begin
            on = (n == 2) ? hi : m_crit[n];
            if (on && !m_cmask[n] && cw < 0) cw = n;
        end
        for (int n = 0; n < 17; n++) begin
            on = (n == 4) ? lo : m_main[n];
            if (on && !m_mmask[(n < 16) ? (15 - n) : 16] && mw < 0) mw = n;
        end
        if (cw >= 0) r = r | 32'h0000_0400 | (32'(cw) << 8);
        if (mw >= 0) r = r | 32'h0020_0000 | (32'(mw) << 16);
        if (pw >= 0) r = r | 32'h2000_0000 | (32'(pw) << 24);
        return r;
    endfunction

    // cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            checks++;
            if (status !== model_status()) begin
                errors++;
                $display("FAIL %s (model): status=%h expected=%h", phase, status, model_status());
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic look(input string tag, input logic [31:0] expv);
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (status !== expv) begin
            errors++;
            $display("FAIL %s: status=%h expected=%h", tag, status, expv);
        end
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] data);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
    endtask

    task automatic pulse_dma(input logic [31:0] v);
        dma_evt = v;
        @(posedge clk);
        #1;
        dma_evt = '0;
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(8 * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            summary();
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        rst_n = 1'b0;
        crit_req = '1; main_req = '1; periph_req = '1; dma_evt = '1;
        cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (status !== 32'h0) begin
            errors++;
            $display("FAIL R1 (in reset): status=%h expected=00000000", status);
        end
        @(posedge clk); #1;
        dma_evt = '0;
        rst_n = 1'b1;
        // R1: masks all ones after reset, all requests high
        phase = "R1";
        look("R1", 32'h0);

        // unmask the three group masks
        phase = "R8";
        wr(3'd0, 32'h0); wr(3'd1, 32'h0); wr(3'd2, 32'h0);
        crit_req = '0; main_req = '0; periph_req = 32'h1 << 7;
        look("R8", 32'h2724_0000);          // peripheral 7 -> main link 4

        phase = "R2";
        periph_req = (32'h1 << 3) | (32'h1 << 9);
        look("R2 R7", 32'h2324_0600);       // both classes, all three fields

        phase = "R7";
        periph_req = '0; crit_req = 4'b0100; main_req = 17'h10;
        look("R7 R8", 32'h0);               // link pins ignored

        phase = "R4";
        crit_req = 4'b1010; main_req = (17'h1 << 16) | (17'h1 << 9);
        look("R4", 32'h0029_0500);

        phase = "R6";
        crit_req = '0; main_req = '0; periph_req = 32'h1;
        look("R6", 32'h0);                  // periph_req[0] ignored
        pulse_dma(32'h20);
        look("R9", 32'h0);                  // pending but DMA-masked
        wr(3'd3, ~32'h20);
        look("R6", 32'h2000_0600);

        phase = "R9";
        wr(3'd4, 32'h20);
        look("R9", 32'h0);                  // acknowledged
        pulse_dma(32'h20);
        look("R9", 32'h2000_0600);
        dma_evt = 32'h20;
        wr(3'd4, 32'h20);                   // set and clear on the same edge
        dma_evt = '0;
        look("R9", 32'h2000_0600);
        wr(3'd3, 32'hFFFF_FFFF);
        look("R9", 32'h0);                  // hidden, not cleared
        wr(3'd3, ~32'h20);
        look("R9", 32'h2000_0600);
        wr(3'd4, 32'hFFFF_FFFF);

        phase = "R10";
        wr(3'd0, 32'h0);
        wr(3'd1, 32'h0001_0FFF);
        wr(3'd2, 32'h7FFF_FC00);
        crit_req = '1; main_req = '1; periph_req = '1;
        look("R10", 32'h3620_0400);

        phase = "R5";
        crit_req = '0; main_req = '0;
        periph_req = (32'h1 << 9) | (32'h1 << 8);
        wr(3'd0, 32'hF);
        wr(3'd2, ~(32'h1 << 22));           // only peripheral 9 enabled
        look("R5", 32'h2900_0000);
        wr(3'd1, ~(32'h1 << 11));           // enable main 4
        look("R5", 32'h2924_0000);
        main_req = 17'h1 << 16;
        wr(3'd1, ~(32'h1 << 16));           // enable main 16 only
        look("R5", 32'h2930_0000);

        phase = "R11";
        wr(3'd5, 32'h0); wr(3'd6, 32'h0); wr(3'd7, 32'h0);
        look("R11", 32'h2930_0000);

        // long mixed run, compared every cycle by the model (R3 timing, R4 ordering)
        phase = "R3";
        for (int i = 0; i < 600; i++) begin
            crit_req   = 4'($urandom);
            main_req   = 17'($urandom) & 17'($urandom);
            periph_req = $urandom & $urandom & $urandom;
            dma_evt    = $urandom & $urandom & $urandom & $urandom;
            cfg_we     = ($urandom % 4) == 0;
            cfg_sel    = 3'($urandom);
            cfg_wdata  = $urandom | $urandom;
            @(posedge clk);
            #1;
        end
        cfg_we = 1'b0; dma_evt = '0;
        @(posedge clk); #1;
        @(negedge clk);
        summary();
    end

endmodule